// File: doc/BRIEF.md
# Overlaid BAR with Mask Shadow

This block holds one base address register for an inbound memory window together with a shadow mask and an enable flag that live at the same register address. A mode bit in a control register decides where a write to that shared address lands: with the mode off, the write sets the window base; with the mode on, the write sets the mask or switches the window on or off. Inbound addresses are compared against the base, with the masked low bits ignored, to produce a hit.

The mode bit crosses into a second clock domain through a two-flop synchronizer. An acknowledge comes back through another two-flop synchronizer, and only that acknowledge is shown when the control register is read. Software writes the mode bit and then polls it until the read value equals the written one. Write routing for the shared address follows the acknowledged mode, so routing and readback always agree.

Top module: `bar_overlay_window`

## Requirements
- R1: After reset the window is disabled, the stored base is zero, the mask output equals the fixed low-bit mask (LOW_BITS ones, 0x0000000F by default) and the mode status reads 0.
- R2: A write to the control address (CTRL_ADDR, default 0) takes bit 5 of the write data as the mode request; a read of the control address returns the mode status in bit 5 and zero in every other bit.
- R3: The mode status does not change in the cycle after the request changes; it follows the request within 12 register-clock cycles, and when it reads 1 the second-domain copy of the mode is also 1.
- R4: With the mode status at 1, writing the value 1 to the BAR address (BAR_ADDR, default 4) sets the enable.
- R5: With the mode status at 1, writing the value 0 to the BAR address clears the enable and leaves the mask unchanged.
- R6: With the mode status at 1, writing any other value to the BAR address loads the mask as that value ORed with the fixed low-bit mask, and leaves the enable and the stored base unchanged.
- R7: With the mode status at 0, a write to the BAR address stores the base; bits covered by the current mask read as zero on the base output and on a read of the BAR address.
- R8: With the mode status at 0, a write to the BAR address leaves the mask and the enable unchanged.
- R9: The hit output is 1 exactly when the enable is set and the probe address, with masked bits ignored, equals the base.
- R10: With the mode status at 1, a read of the BAR address returns the mask with bit 0 replaced by the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset, register domain |
| core_clk | input | 1 | Second-domain clock |
| core_rst_n | input | 1 | Active-low asynchronous reset, second domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for addr (combinational) |
| probe_addr | input | DW (32) | Inbound address to compare |
| probe_hit | output | 1 | Inbound address falls in the enabled window |
| bar_base | output | DW (32) | Stored base with masked bits zero |
| bar_mask | output | DW (32) | Effective mask |
| bar_enable | output | 1 | Window enable |
| ovl_mode | output | 1 | Acknowledged mode status |
| core_ovl_mode | output | 1 | Mode as seen in the second domain |

## Verification
The hardest situation to reach is the window in which the mode request has changed but the acknowledge has not yet returned, since it lasts only a few cycles and depends on two unrelated clocks. The bench writes the control register and reads it back on the very next cycle, when the old status must still be visible, then polls with a cycle count so the return time is bounded. Base-then-mask ordering is also exercised: a base written under a small mask is later shrunk by a larger mask, and the probe is driven on both edges of the resulting window.

// File: rtl/bar_ovl_pkg.sv
package bar_ovl_pkg;
   typedef enum logic [1:0] {
      OVL_OP_DISABLE,
      OVL_OP_ENABLE,
      OVL_OP_MASK
   } ovl_op_e;

   function automatic ovl_op_e classify_ovl(input logic [31:0] value);
      if (value == 32'd0)      return OVL_OP_DISABLE;
      else if (value == 32'd1) return OVL_OP_ENABLE;
      else                     return OVL_OP_MASK;
   endfunction
endpackage

// File: rtl/bar_ovl_sync.sv
module bar_ovl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bar_ovl_mode_xing.sv
module bar_ovl_mode_xing #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_clk,
   input  logic core_rst_n,
   input  logic req,
   output logic core_mode,
   output logic status
);
   bar_ovl_sync #(.STAGES(STAGES)) u_fwd (
      .clk  (core_clk),
      .rst_n(core_rst_n),
      .d    (req),
      .q    (core_mode)
   );

   bar_ovl_sync #(.STAGES(STAGES)) u_back (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (core_mode),
      .q    (status)
   );
endmodule

// File: rtl/bar_ovl_regs.sv
module bar_ovl_regs
   import bar_ovl_pkg::*;
#(
   parameter int DW       = 32,
   parameter int LOW_BITS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bar_wr,
   input  logic          ovl,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] bar_base,
   output logic [DW-1:0] eff_mask,
   output logic          enable,
   output logic [DW-1:0] ovl_rdata
);
   localparam logic [DW-1:0] LOW_FIX = (DW'(1) << LOW_BITS) - DW'(1);

   logic [DW-1:0] bar_q;
   logic [DW-1:0] mask_q;
   logic          en_q;
   ovl_op_e       op;

   assign op       = classify_ovl(32'(wdata));
   assign eff_mask = mask_q | LOW_FIX;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bar_q  <= '0;
         mask_q <= '0;
         en_q   <= 1'b0;
      end else if (bar_wr) begin
         if (ovl) begin
            case (op)
               OVL_OP_DISABLE: en_q   <= 1'b0;
               OVL_OP_ENABLE:  en_q   <= 1'b1;
               default:        mask_q <= wdata;
            endcase
         end else begin
            bar_q <= wdata & ~eff_mask;
         end
      end
   end

   assign bar_base  = bar_q & ~eff_mask;
   assign enable    = en_q;
   assign ovl_rdata = {eff_mask[DW-1:1], en_q};

   // R4: a one in overlay mode turns the window on
   a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_wr && ovl && wdata == DW'(1)) |=> enable);
   // R5: a zero in overlay mode turns it off and keeps the mask
   a_r5_disable_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_wr && ovl && wdata == '0) |=> (!enable && $stable(eff_mask)));
   // R6: overlay writes never touch the stored base
   a_r6_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_wr && ovl) |=> $stable(bar_q));
   // R8: base writes never touch mask or enable
   a_r8_normal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_wr && !ovl) |=> ($stable(eff_mask) && $stable(enable)));
endmodule

// File: rtl/bar_ovl_match.sv
module bar_ovl_match #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] probe_addr,
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] mask,
   input  logic          enable,
   output logic          hit
);
   logic [DW-1:0] diff;

   assign diff = (probe_addr ^ base) & ~mask;
   assign hit  = enable && (diff == '0);
endmodule

// File: rtl/bar_overlay_window.sv
module bar_overlay_window #(
   parameter int DW          = 32,
   parameter int ADDR_W      = 4,
   parameter int CTRL_ADDR   = 0,
   parameter int BAR_ADDR    = 4,
   parameter int MODE_BIT    = 5,
   parameter int LOW_BITS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_clk,
   input  logic              core_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [DW-1:0]     probe_addr,
   output logic              probe_hit,
   output logic [DW-1:0]     bar_base,
   output logic [DW-1:0]     bar_mask,
   output logic              bar_enable,
   output logic              ovl_mode,
   output logic              core_ovl_mode
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] BAR_A  = ADDR_W'(BAR_ADDR);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MODE_BIT >= DW || LOW_BITS >= DW || DW > 32) begin : g_bad_width
      $error("MODE_BIT and LOW_BITS must lie below DW, and DW at most 32");
   end
   if (CTRL_ADDR == BAR_ADDR || CTRL_ADDR >= (1 << ADDR_W) || BAR_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses must be distinct and fit ADDR_W");
   end

   logic          mode_req_q;
   logic          bar_wr;
   logic [DW-1:0] ovl_rdata;
   logic [DW-1:0] ctrl_rdata;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        mode_req_q <= 1'b0;
      else if (wr_en && addr == CTRL_A)  mode_req_q <= wdata[MODE_BIT];

   assign bar_wr = wr_en && (addr == BAR_A);

   bar_ovl_mode_xing #(.STAGES(SYNC_STAGES)) u_xing (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_clk  (core_clk),
      .core_rst_n(core_rst_n),
      .req       (mode_req_q),
      .core_mode (core_ovl_mode),
      .status    (ovl_mode)
   );

   bar_ovl_regs #(.DW(DW), .LOW_BITS(LOW_BITS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bar_wr   (bar_wr),
      .ovl      (ovl_mode),
      .wdata    (wdata),
      .bar_base (bar_base),
      .eff_mask (bar_mask),
      .enable   (bar_enable),
      .ovl_rdata(ovl_rdata)
   );

   bar_ovl_match #(.DW(DW)) u_match (
      .probe_addr(probe_addr),
      .base      (bar_base),
      .mask      (bar_mask),
      .enable    (bar_enable),
      .hit       (probe_hit)
   );

   always_comb begin
      ctrl_rdata           = '0;
      ctrl_rdata[MODE_BIT] = ovl_mode;
   end

   always_comb begin
      if (addr == CTRL_A)     rdata = ctrl_rdata;
      else if (addr == BAR_A) rdata = ovl_mode ? ovl_rdata : bar_base;
      else                    rdata = '0;
   end

   // R9: no hit while the window is off
   a_r9_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      probe_hit |-> bar_enable);
   // R3: a request change is not visible in the status on the next cycle
   a_r3_status_lags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == CTRL_A && wdata[MODE_BIT] != mode_req_q && mode_req_q == ovl_mode)
      |=> (ovl_mode == $past(ovl_mode)));
endmodule

// File: tb/bar_overlay_window_test.sv
module bar_overlay_window_test;
   logic        clk = 1'b0;
   logic        core_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] probe_addr = '0;
   logic        probe_hit;
   logic [31:0] bar_base;
   logic [31:0] bar_mask;
   logic        bar_enable;
   logic        ovl_mode;
   logic        core_ovl_mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;
   always #7 core_clk = ~core_clk;

   bar_overlay_window uut (
      .clk(clk), .rst_n(rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .probe_addr(probe_addr), .probe_hit(probe_hit),
      .bar_base(bar_base), .bar_mask(bar_mask), .bar_enable(bar_enable),
      .ovl_mode(ovl_mode), .core_ovl_mode(core_ovl_mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_mode(input logic on);
      logic [31:0] v;
      int n;
      logic [31:0] prev;
      prev = {26'd0, ~on, 5'd0};
      wr(4'd0, on ? 32'hFFFF_FFFF : 32'h0000_0000);
      rd(4'd0, v);
      chk("R3 lag", v, prev);
      n = 0;
      while (v !== {26'd0, on, 5'd0} && n < 40) begin
         @(negedge clk);
         n++;
         rd(4'd0, v);
      end
      chk("R2 ctrl readback", v, {26'd0, on, 5'd0});
      chk("R3 bounded delay", 32'(n <= 12), 32'd1);
      chk("R3 core view", {31'd0, core_ovl_mode}, {31'd0, on});
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 base", bar_base, 32'h0);
      chk("R1 mask", bar_mask, 32'h0000_000F);
      chk("R1 enable", {31'd0, bar_enable}, 32'd0);
      chk("R1 status", {31'd0, ovl_mode}, 32'd0);
      rd(4'd0, v);
      chk("R1 ctrl read", v, 32'h0);
   endtask

   task automatic t_base_write;
      logic [31:0] v;
      wr(4'd4, 32'h1234_5678);
      chk("R7 base low bits", bar_base, 32'h1234_5670);
      rd(4'd4, v);
      chk("R7 base read", v, 32'h1234_5670);
      chk("R8 mask kept", bar_mask, 32'h0000_000F);
      chk("R8 enable kept", {31'd0, bar_enable}, 32'd0);
      probe_addr = 32'h1234_5670;
      #1 chk("R9 disabled no hit", {31'd0, probe_hit}, 32'd0);
   endtask

   task automatic t_overlay;
      logic [31:0] v;
      wr(4'd4, 32'h0000_0FFF);
      chk("R6 mask load", bar_mask, 32'h0000_0FFF);
      chk("R6 enable kept", {31'd0, bar_enable}, 32'd0);
      chk("R6 base masked view", bar_base, 32'h1234_5000);
      rd(4'd4, v);
      chk("R10 read disabled", v, 32'h0000_0FFE);
      wr(4'd4, 32'h0000_0001);
      chk("R4 enable", {31'd0, bar_enable}, 32'd1);
      chk("R4 mask kept", bar_mask, 32'h0000_0FFF);
      rd(4'd4, v);
      chk("R10 read enabled", v, 32'h0000_0FFF);
      wr(4'd4, 32'h0000_0000);
      chk("R5 disable", {31'd0, bar_enable}, 32'd0);
      chk("R5 mask kept", bar_mask, 32'h0000_0FFF);
      wr(4'd4, 32'h0000_0001);
      chk("R4 re-enable", {31'd0, bar_enable}, 32'd1);
      wr(4'd4, 32'h0000_0100);
      chk("R6 low bits forced", bar_mask, 32'h0000_010F);
      wr(4'd4, 32'h0000_0FFF);
   endtask

   task automatic t_base_again;
      logic [31:0] v;
      wr(4'd4, 32'hABCD_EFFF);
      chk("R7 masked bits dropped", bar_base, 32'hABCD_E000);
      rd(4'd4, v);
      chk("R7 read base", v, 32'hABCD_E000);
      chk("R8 mask kept", bar_mask, 32'h0000_0FFF);
      chk("R8 enable kept", {31'd0, bar_enable}, 32'd1);
   endtask

   task automatic t_hit;
      probe_addr = 32'hABCD_E123; #1 chk("R9 inside", {31'd0, probe_hit}, 32'd1);
      probe_addr = 32'hABCD_EFFF; #1 chk("R9 top edge", {31'd0, probe_hit}, 32'd1);
      probe_addr = 32'hABCD_E000; #1 chk("R9 bottom edge", {31'd0, probe_hit}, 32'd1);
      probe_addr = 32'hABCD_F000; #1 chk("R9 above", {31'd0, probe_hit}, 32'd0);
      probe_addr = 32'hABCD_DFFF; #1 chk("R9 below", {31'd0, probe_hit}, 32'd0);
   endtask

   task automatic t_disable_hit;
      set_mode(1'b1);
      wr(4'd4, 32'h0000_0000);
      probe_addr = 32'hABCD_E123;
      #1 chk("R9 disabled miss", {31'd0, probe_hit}, 32'd0);
      chk("R6 base kept", bar_base, 32'hABCD_E000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; core_rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_base_write();
      set_mode(1'b1);
      t_overlay();
      set_mode(1'b0);
      t_base_again();
      t_hit();
      t_disable_hit();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule